// File: doc/BRIEF.md
# Dual-Mode Pin Control Arbiter

This block sits between the configuration sources of a coaxial video-link receiver and the analog blocks those sources steer. A mode-select input decides who is in charge: with it low, four shared multi-function pins act as direct controls for bypass, automatic sleep and mute, and one of them carries an active-low signal-detect indication outward; with it high, a set of register fields drives the same decisions and the shared pins are handed to a serial configuration port, with a different pin carrying the signal-detect indication.

The arbiter merges the chosen requests into a single resolved operating state with a fixed priority: sleep beats mute, and mute beats bypass. From that state and from the detected data-rate code it produces registered enables for the equalizer, the jitter cleaner, the two bypass paths, the output mute, power-down and every output driver, plus the direction and value of each shared pin. A dedicated hardware pin can switch off the last output driver whatever the register setting says.

The resolved state is one of five: SLEEP, MUTE, FULL_BYP (equalizer and jitter cleaner both bypassed), JC_BYP (only the jitter cleaner bypassed) and RUN. The state is re-resolved from the inputs on every clock, so every state can move to every other state; the transition taken is chosen by the precedence: to SLEEP whenever sleep is requested, else to MUTE when mute is requested, else to FULL_BYP, else to JC_BYP, else to RUN. Reset places the block in SLEEP.

Top module: `pin_ctrl_arbiter`

## Requirements
- R1: While rst_n is low, every output is 0 except power_down_o, which is 1; the resolved state is SLEEP and no shared pin is driven (mf_oe_o = 0000).
- R2: With mode_sw_i = 0 the requests come only from the pin inputs (byp_hi_i, byp_float_i, autosleep_pin_i, mute_pin_i); with mode_sw_i = 1 they come only from the register inputs (sw_sleep_code_i, sw_mute_i, sw_eq_bypass_i, sw_jc_bypass_i), and the other set has no effect on any output.
- R3: In pin mode the three-level bypass pin arrives as two decoded bits: byp_hi_i = 1 selects full bypass (equalizer and jitter cleaner), byp_hi_i = 0 with byp_float_i = 1 selects jitter-cleaner-only bypass, both 0 selects normal operation. In register mode sw_eq_bypass_i = 1 selects full bypass and otherwise sw_jc_bypass_i = 1 selects jitter-cleaner-only bypass.
- R4: Sleep has priority over mute, and mute has priority over both bypass requests. SLEEP gives power_down_o = 1 with all other enables, bypasses, mute and every driver enable at 0; MUTE gives mute_o = 1 and eq_en_o = 1 with both bypass outputs 0; FULL_BYP gives full_bypass_o = 1 with eq_en_o and jc_en_o at 0; JC_BYP gives jc_bypass_o = 1 and eq_en_o = 1 with jc_en_o at 0; RUN gives eq_en_o = 1.
- R5: In pin mode, autosleep_pin_i = 1 requests sleep only while sig_present_i = 0; autosleep_pin_i = 0 never requests sleep.
- R6: In register mode sw_sleep_code_i is decoded as 00 = never sleep, 01 = sleep while sig_present_i = 0, 10 = always sleep, 11 (reserved) = never sleep.
- R7: The internal no-signal indication is 1 when sig_present_i = 0 or cable_over_i = 1. It is driven on mf_out_o[3] in pin mode and on mf_out_o[0] in register mode.
- R8: drv_en_o[i] equals drv_cfg_en_i[i] outside SLEEP, except that drv_last_dis_pin_i = 1 forces the highest-index driver enable to 0 in both modes.
- R9: jc_en_o can be 1 only in RUN or MUTE, and only when rate_code_i is 01 (HD) or 10 (3G); codes 00 (SD) and 11 (undetermined) keep the jitter cleaner off.
- R10: Pin mode drives mf_oe_o = 1000 (only pin 3 is an output); register mode drives mf_oe_o = 0011 with mf_out_o[1] = ser_so_i and mf_out_o[2], mf_out_o[3] at 0. Undriven pins carry 0 on mf_out_o.
- R11: Every output reflects the inputs sampled at the previous rising clock edge: exactly one register stage from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sw_i | input | 1 | 0 = pin control, 1 = register control |
| byp_hi_i | input | 1 | Bypass pin decoded as driven high |
| byp_float_i | input | 1 | Bypass pin decoded as floating |
| autosleep_pin_i | input | 1 | Pin-mode automatic sleep request |
| mute_pin_i | input | 1 | Pin-mode mute request |
| sig_present_i | input | 1 | Input signal present |
| cable_over_i | input | 1 | Estimated cable length beyond mute threshold |
| sw_sleep_code_i | input | 2 | Register sleep field |
| sw_mute_i | input | 1 | Register mute bit |
| sw_eq_bypass_i | input | 1 | Register full-bypass bit |
| sw_jc_bypass_i | input | 1 | Register jitter-cleaner bypass bit |
| rate_code_i | input | 2 | Detected rate: 00 SD, 01 HD, 10 3G, 11 undetermined |
| drv_cfg_en_i | input | NUM_DRV | Register enable per output driver |
| drv_last_dis_pin_i | input | 1 | Hardware disable of the highest-index driver |
| ser_so_i | input | 1 | Serial port data out, routed to pin 1 in register mode |
| eq_en_o | output | 1 | Equalizer enable |
| jc_en_o | output | 1 | Jitter cleaner enable |
| full_bypass_o | output | 1 | Bypass equalizer and jitter cleaner |
| jc_bypass_o | output | 1 | Bypass jitter cleaner only |
| mute_o | output | 1 | Output mute |
| power_down_o | output | 1 | Equalizer power-down |
| drv_en_o | output | NUM_DRV | Per-driver enable |
| mf_oe_o | output | 4 | Shared pin output enables |
| mf_out_o | output | 4 | Shared pin output values |

## Verification
The hardest situation to reach is one where every request is raised at once and the winner must change because of a single low-priority input, such as register sleep code 01 flipping between SLEEP and MUTE as sig_present_i toggles while both bypass requests stay high. The bench builds these stacks deliberately, holding mute and both bypass bits active in both modes and then walking the sleep source, the signal-present input and the sleep code through all their values. It also drives the unselected control set to opposite values during each mode so that any leak between sources shows at the outputs, and follows with a long stretch of random input combinations compared against its reference model on every clock.

// File: rtl/pin_arb_pkg.sv
package pin_arb_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP    = 3'd0,
        ST_MUTE     = 3'd1,
        ST_FULL_BYP = 3'd2,
        ST_JC_BYP   = 3'd3,
        ST_RUN      = 3'd4
    } arb_state_e;

    typedef struct packed {
        logic sleep;
        logic mute;
        logic full_byp;
        logic jc_byp;
    } arb_req_t;

    localparam logic [1:0] SLP_NEVER   = 2'b00;
    localparam logic [1:0] SLP_NO_SIG  = 2'b01;
    localparam logic [1:0] SLP_ALWAYS  = 2'b10;
    localparam logic [1:0] SLP_RSVD    = 2'b11;

    localparam logic [1:0] RATE_SD     = 2'b00;
    localparam logic [1:0] RATE_HD     = 2'b01;
    localparam logic [1:0] RATE_3G     = 2'b10;

endpackage

// File: rtl/arb_src_sel.sv
module arb_src_sel
    import pin_arb_pkg::*;
(
    input  logic       mode_sw_i,
    input  logic       byp_hi_i,
    input  logic       byp_float_i,
    input  logic       autosleep_pin_i,
    input  logic       mute_pin_i,
    input  logic       sig_present_i,
    input  logic [1:0] sw_sleep_code_i,
    input  logic       sw_mute_i,
    input  logic       sw_eq_bypass_i,
    input  logic       sw_jc_bypass_i,
    output arb_req_t   req_o
);

    arb_req_t pin_req;
    arb_req_t reg_req;
    logic     reg_sleep;

    // Pin path: the three-level bypass pin is already split into two bits.
    always_comb begin
        pin_req.sleep    = autosleep_pin_i & ~sig_present_i;
        pin_req.mute     = mute_pin_i;
        pin_req.full_byp = byp_hi_i;
        pin_req.jc_byp   = ~byp_hi_i & byp_float_i;
    end

    // Register path: reserved sleep code behaves as "never sleep".
    always_comb begin
        unique case (sw_sleep_code_i)
            SLP_NEVER:  reg_sleep = 1'b0;
            SLP_NO_SIG: reg_sleep = ~sig_present_i;
            SLP_ALWAYS: reg_sleep = 1'b1;
            SLP_RSVD:   reg_sleep = 1'b0;
            default:    reg_sleep = 1'b0;
        endcase
    end

    always_comb begin
        reg_req.sleep    = reg_sleep;
        reg_req.mute     = sw_mute_i;
        reg_req.full_byp = sw_eq_bypass_i;
        reg_req.jc_byp   = ~sw_eq_bypass_i & sw_jc_bypass_i;
    end

    assign req_o = mode_sw_i ? reg_req : pin_req;

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import pin_arb_pkg::*;
#(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  arb_req_t          req_i,
    input  logic [RATE_W-1:0] rate_code_i,
    output arb_state_e        state_o,
    output logic              eq_en_o,
    output logic              jc_en_o,
    output logic              full_bypass_o,
    output logic              jc_bypass_o,
    output logic              mute_o,
    output logic              power_down_o
);

    arb_state_e state_q;
    arb_state_e state_d;
    logic       rate_ok;

    assign rate_ok = (rate_code_i == RATE_W'(RATE_HD)) ||
                     (rate_code_i == RATE_W'(RATE_3G));

    // Precedence: sleep, then mute, then full bypass, then cleaner-only bypass.
    always_comb begin
        if (req_i.sleep)         state_d = ST_SLEEP;
        else if (req_i.mute)     state_d = ST_MUTE;
        else if (req_i.full_byp) state_d = ST_FULL_BYP;
        else if (req_i.jc_byp)   state_d = ST_JC_BYP;
        else                     state_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_en_o       <= 1'b0;
            jc_en_o       <= 1'b0;
            full_bypass_o <= 1'b0;
            jc_bypass_o   <= 1'b0;
            mute_o        <= 1'b0;
            power_down_o  <= 1'b1;
        end else begin
            eq_en_o       <= 1'b0;
            jc_en_o       <= 1'b0;
            full_bypass_o <= 1'b0;
            jc_bypass_o   <= 1'b0;
            mute_o        <= 1'b0;
            power_down_o  <= 1'b0;
            unique case (state_d)
                ST_SLEEP: begin
                    power_down_o <= 1'b1;
                end
                ST_MUTE: begin
                    mute_o  <= 1'b1;
                    eq_en_o <= 1'b1;
                    jc_en_o <= rate_ok;
                end
                ST_FULL_BYP: begin
                    full_bypass_o <= 1'b1;
                end
                ST_JC_BYP: begin
                    eq_en_o     <= 1'b1;
                    jc_bypass_o <= 1'b1;
                end
                ST_RUN: begin
                    eq_en_o <= 1'b1;
                    jc_en_o <= rate_ok;
                end
                default: begin
                    power_down_o <= 1'b1;
                end
            endcase
        end
    end

    assign state_o = state_q;

    assert_sleep_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_i.sleep |=> (state_q == ST_SLEEP) && power_down_o && !mute_o);

    assert_mute_over_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i.sleep && req_i.mute) |=> mute_o && !full_bypass_o && !jc_bypass_o);

    assert_jc_rate_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_ok |=> !jc_en_o);

    assert_pd_excludes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        power_down_o |-> !eq_en_o && !jc_en_o && (state_q == ST_SLEEP));

endmodule

// File: rtl/arb_drv_en.sv
module arb_drv_en #(
    parameter int NUM_DRV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DRV-1:0] drv_cfg_en_i,
    input  logic               drv_last_dis_pin_i,
    input  logic               sleep_i,
    output logic [NUM_DRV-1:0] drv_en_o
);

    localparam int LAST = NUM_DRV - 1;

    for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
        logic allow;
        if (i == LAST && NUM_DRV > 1) begin : g_pin_gated
            assign allow = drv_cfg_en_i[i] & ~drv_last_dis_pin_i;

            assert_pin_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
                drv_last_dis_pin_i |=> !drv_en_o[i]);
        end else begin : g_reg_only
            assign allow = drv_cfg_en_i[i];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) drv_en_o[i] <= 1'b0;
            else        drv_en_o[i] <= allow & ~sleep_i;
        end
    end

    assert_sleep_drv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (drv_en_o == '0));

endmodule

// File: rtl/arb_pin_dir.sv
module arb_pin_dir #(
    parameter int NUM_MF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sw_i,
    input  logic              sig_present_i,
    input  logic              cable_over_i,
    input  logic              ser_so_i,
    output logic [NUM_MF-1:0] mf_oe_o,
    output logic [NUM_MF-1:0] mf_out_o
);

    localparam int PIN_SD_SW  = 0;
    localparam int PIN_SO_SW  = 1;
    localparam int PIN_SD_HW  = NUM_MF - 1;

    logic              no_sig;
    logic [NUM_MF-1:0] oe_d;
    logic [NUM_MF-1:0] out_d;

    assign no_sig = ~sig_present_i | cable_over_i;

    always_comb begin
        oe_d  = '0;
        out_d = '0;
        if (mode_sw_i) begin
            oe_d[PIN_SD_SW]  = 1'b1;
            oe_d[PIN_SO_SW]  = 1'b1;
            out_d[PIN_SD_SW] = no_sig;
            out_d[PIN_SO_SW] = ser_so_i;
        end else begin
            oe_d[PIN_SD_HW]  = 1'b1;
            out_d[PIN_SD_HW] = no_sig;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mf_oe_o  <= '0;
            mf_out_o <= '0;
        end else begin
            mf_oe_o  <= oe_d;
            mf_out_o <= out_d;
        end
    end

    assert_hw_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sw_i |=> mf_oe_o[PIN_SD_HW] && !mf_oe_o[PIN_SD_SW] && !mf_oe_o[PIN_SO_SW]);

    assert_sw_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sw_i |=> mf_oe_o[PIN_SD_SW] && mf_oe_o[PIN_SO_SW] && !mf_oe_o[PIN_SD_HW]);

    assert_nosig_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_present_i && !mode_sw_i) |=> mf_out_o[PIN_SD_HW]);

    assert_undriven_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mf_out_o & ~mf_oe_o) == '0));

endmodule

// File: rtl/pin_ctrl_arbiter.sv
module pin_ctrl_arbiter
    import pin_arb_pkg::*;
#(
    parameter int NUM_DRV = 2,
    parameter int RATE_W  = 2,
    parameter int NUM_MF  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_sw_i,
    input  logic               byp_hi_i,
    input  logic               byp_float_i,
    input  logic               autosleep_pin_i,
    input  logic               mute_pin_i,
    input  logic               sig_present_i,
    input  logic               cable_over_i,
    input  logic [1:0]         sw_sleep_code_i,
    input  logic               sw_mute_i,
    input  logic               sw_eq_bypass_i,
    input  logic               sw_jc_bypass_i,
    input  logic [RATE_W-1:0]  rate_code_i,
    input  logic [NUM_DRV-1:0] drv_cfg_en_i,
    input  logic               drv_last_dis_pin_i,
    input  logic               ser_so_i,
    output logic               eq_en_o,
    output logic               jc_en_o,
    output logic               full_bypass_o,
    output logic               jc_bypass_o,
    output logic               mute_o,
    output logic               power_down_o,
    output logic [NUM_DRV-1:0] drv_en_o,
    output logic [NUM_MF-1:0]  mf_oe_o,
    output logic [NUM_MF-1:0]  mf_out_o
);

    arb_req_t   req;
    arb_state_e state;

    arb_src_sel u_src_sel (
        .mode_sw_i       (mode_sw_i),
        .byp_hi_i        (byp_hi_i),
        .byp_float_i     (byp_float_i),
        .autosleep_pin_i (autosleep_pin_i),
        .mute_pin_i      (mute_pin_i),
        .sig_present_i   (sig_present_i),
        .sw_sleep_code_i (sw_sleep_code_i),
        .sw_mute_i       (sw_mute_i),
        .sw_eq_bypass_i  (sw_eq_bypass_i),
        .sw_jc_bypass_i  (sw_jc_bypass_i),
        .req_o           (req)
    );

    arb_fsm #(.RATE_W(RATE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .rate_code_i   (rate_code_i),
        .state_o       (state),
        .eq_en_o       (eq_en_o),
        .jc_en_o       (jc_en_o),
        .full_bypass_o (full_bypass_o),
        .jc_bypass_o   (jc_bypass_o),
        .mute_o        (mute_o),
        .power_down_o  (power_down_o)
    );

    arb_drv_en #(.NUM_DRV(NUM_DRV)) u_drv (
        .clk                (clk),
        .rst_n              (rst_n),
        .drv_cfg_en_i       (drv_cfg_en_i),
        .drv_last_dis_pin_i (drv_last_dis_pin_i),
        .sleep_i            (req.sleep),
        .drv_en_o           (drv_en_o)
    );

    arb_pin_dir #(.NUM_MF(NUM_MF)) u_pins (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_sw_i     (mode_sw_i),
        .sig_present_i (sig_present_i),
        .cable_over_i  (cable_over_i),
        .ser_so_i      (ser_so_i),
        .mf_oe_o       (mf_oe_o),
        .mf_out_o      (mf_out_o)
    );

    assert_state_drv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> (drv_en_o == '0));

    assert_one_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full_bypass_o, jc_bypass_o, mute_o, power_down_o}));

endmodule

// File: tb/pin_ctrl_arbiter_tb.sv
`timescale 1ns/1ps
module pin_ctrl_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sw = 1'b0, byp_hi = 1'b0, byp_fl = 1'b0;
    logic       as_pin = 1'b0, mu_pin = 1'b0, present = 1'b1, over = 1'b0;
    logic [1:0] slp_code = 2'b00;
    logic       sw_mu = 1'b0, sw_eb = 1'b0, sw_jb = 1'b0;
    logic [1:0] rate = 2'b01;
    logic [1:0] cfg = 2'b11;
    logic       dis_pin = 1'b0, so = 1'b0;

    logic       eq_en, jc_en, fb, jb, mu, pd;
    logic [1:0] drv;
    logic [3:0] oe, mfo;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pin_ctrl_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sw_i(mode_sw), .byp_hi_i(byp_hi),
        .byp_float_i(byp_fl), .autosleep_pin_i(as_pin), .mute_pin_i(mu_pin),
        .sig_present_i(present), .cable_over_i(over), .sw_sleep_code_i(slp_code),
        .sw_mute_i(sw_mu), .sw_eq_bypass_i(sw_eb), .sw_jc_bypass_i(sw_jb),
        .rate_code_i(rate), .drv_cfg_en_i(cfg), .drv_last_dis_pin_i(dis_pin),
        .ser_so_i(so), .eq_en_o(eq_en), .jc_en_o(jc_en), .full_bypass_o(fb),
        .jc_bypass_o(jb), .mute_o(mu), .power_down_o(pd), .drv_en_o(drv),
        .mf_oe_o(oe), .mf_out_o(mfo)
    );

    // Reference model: packed as {eq,jc,fb,jb,mu,pd,drv[1:0],oe[3:0],out[3:0]}
    function automatic logic [15:0] model();
        logic s, m, f, j, nosig, good_rate;
        logic e_eq, e_jc, e_fb, e_jb, e_mu, e_pd;
        logic [1:0] e_drv;
        logic [3:0] e_oe, e_out;
        nosig = !present || over;
        good_rate = (rate == 2'd1) || (rate == 2'd2);
        if (!mode_sw) begin
            s = as_pin && !present;
            m = mu_pin;
            f = byp_hi;
            j = byp_fl;
        end else begin
            s = (slp_code == 2'd2) || (slp_code == 2'd1 && !present);
            m = sw_mu;
            f = sw_eb;
            j = sw_jb;
        end
        {e_eq, e_jc, e_fb, e_jb, e_mu, e_pd} = 6'b0;
        if (s)      e_pd = 1;
        else if (m) begin e_mu = 1; e_eq = 1; e_jc = good_rate; end
        else if (f) e_fb = 1;
        else if (j) begin e_jb = 1; e_eq = 1; end
        else        begin e_eq = 1; e_jc = good_rate; end
        e_drv = s ? 2'b00 : cfg;
        if (dis_pin) e_drv[1] = 1'b0;
        if (mode_sw) begin e_oe = 4'b0011; e_out = {2'b00, so, nosig}; end
        else         begin e_oe = 4'b1000; e_out = {nosig, 3'b000}; end
        return {e_eq, e_jc, e_fb, e_jb, e_mu, e_pd, e_drv, e_oe, e_out};
    endfunction

    function automatic logic [15:0] observed();
        return {eq_en, jc_en, fb, jb, mu, pd, drv, oe, mfo};
    endfunction

    task automatic compare(input string tag, input logic [15:0] exp_v);
        logic [15:0] got;
        got = observed();
        checks++;
        if (got !== exp_v) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp_v);
        end
    endtask

    // Inputs are set 1 ns after a rising edge; result is read 1 ns after the next one.
    task automatic step(input string tag);
        logic [15:0] e;
        e = model();
        @(posedge clk);
        #1;
        compare(tag, e);
    endtask

    task automatic pins(input logic bh, input logic bf, input logic a, input logic mp);
        byp_hi = bh; byp_fl = bf; as_pin = a; mu_pin = mp;
    endtask

    task automatic regs(input logic [1:0] c, input logic mm, input logic eb, input logic jbb);
        slp_code = c; sw_mu = mm; sw_eb = eb; sw_jb = jbb;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with busy inputs to show reset wins
        pins(1, 0, 1, 1); present = 0; mode_sw = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", 16'b000001_00_0000_0000);
        rst_n = 1;
        pins(0, 0, 0, 0); present = 1;
        step("R11 first cycle after reset");

        // R3: tri-level bypass decode in pin mode
        pins(1, 0, 0, 0); step("R3 pin high full bypass");
        pins(0, 1, 0, 0); step("R3 pin float cleaner bypass");
        pins(1, 1, 0, 0); step("R3 high dominates float");
        pins(0, 0, 0, 0); step("R3 pin low normal");

        // R5: auto sleep
        as_pin = 1; present = 1; step("R5 autosleep with signal");
        present = 0; step("R5 autosleep no signal");
        as_pin = 0; step("R5 autosleep off no signal");
        present = 1;

        // R4: precedence in pin mode
        pins(1, 1, 1, 1); present = 0; step("R4 sleep over all");
        present = 1; step("R4 mute over bypass");
        mu_pin = 0; step("R4 bypass after mute drops");

        // R7: no-signal flag with cable threshold
        pins(0, 0, 0, 0); over = 1; step("R7 cable over hw pin3");
        over = 0; present = 0; step("R7 no signal hw pin3");
        present = 1; step("R7 clear hw");

        // R2 / R10: switch to register mode with pin inputs held busy
        pins(1, 1, 1, 1); present = 0; mode_sw = 1; regs(2'b00, 0, 0, 0);
        so = 1; step("R2 pins ignored in reg mode");
        so = 0; present = 1; step("R10 reg mode pin dir");
        over = 1; step("R7 cable over reg pin0");
        over = 0;

        // R6: sleep code decode
        regs(2'b01, 1, 1, 1); present = 1; step("R6 code01 with signal");
        present = 0; step("R6 code01 no signal");
        regs(2'b10, 1, 1, 1); present = 1; step("R6 code10 forced sleep");
        regs(2'b11, 1, 1, 1); present = 0; step("R6 code11 reserved enable");
        regs(2'b00, 0, 1, 1); step("R3 reg full bypass");
        regs(2'b00, 0, 0, 1); present = 1; step("R3 reg cleaner bypass");
        regs(2'b00, 0, 0, 0); step("R4 reg run");

        // R9: rate gating
        for (int r = 0; r < 4; r++) begin
            rate = 2'(r);
            step("R9 rate code run");
        end
        sw_mu = 1; rate = 2'b10; step("R9 rate 3G muted");
        rate = 2'b00; step("R9 rate SD muted");
        sw_mu = 0; rate = 2'b01;

        // R8: driver enables and hardware override in both modes
        cfg = 2'b10; step("R8 cfg only high driver");
        dis_pin = 1; step("R8 pin disables last reg mode");
        cfg = 2'b01; dis_pin = 0; step("R8 cfg low driver");
        mode_sw = 0; pins(0, 0, 0, 0); cfg = 2'b11; dis_pin = 1;
        step("R8 pin disables last hw mode");
        dis_pin = 0; regs(2'b10, 1, 1, 1); step("R2 regs ignored in pin mode");

        // R11: random stream, compared every cycle
        for (int k = 0; k < 600; k++) begin
            logic [19:0] v;
            v = 20'($urandom);
            mode_sw = v[0]; byp_hi = v[1]; byp_fl = v[2]; as_pin = v[3];
            mu_pin = v[4]; present = v[5] | v[6]; over = v[7];
            slp_code = v[9:8]; sw_mu = v[10]; sw_eb = v[11]; sw_jb = v[12];
            rate = v[14:13]; cfg = v[16:15]; dis_pin = v[17]; so = v[18];
            step("R11 random");
        end

        // R1: reset re-entry mid-run
        rst_n = 0;
        @(posedge clk); #1;
        compare("R1 reset mid-run", 16'b000001_00_0000_0000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule